// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steers a microprogrammed control unit through its control store. Each clock it decides which 7-bit control-store address comes next. The decision uses three fields of the microinstruction now executing: a 2-bit test selector, a 2-bit branch kind and a 7-bit target address. It also uses three datapath status flags and the 4-bit opcode of the instruction held in the data register. The block keeps two registers: the current control address, which is also its output, and a single saved return address for subroutine calls.

One of four sources feeds the address register: the incremented current address, the target field, the saved return address, or an address built from the opcode. A small input-logic function picks the source from the branch kind and the chosen test bit. The return register is written only when a call is taken. There is no stack, so a second call discards the first return address. A synchronous reset places the sequencer at the start of the fetch routine.

Top module: `uaddr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `car_q` becomes 64 and the saved return address becomes 0. A return issued as the first step after reset therefore goes to address 0.
- R2: `cond_sel` chooses the test bit. 0 means always true, 1 means `st_indirect`, 2 means `st_sign` and 3 means `st_zero`.
- R3: With `br_kind` 0 (jump) and a true test bit, the next `car_q` equals `addr_fld`.
- R4: With `br_kind` 0 or 1 and a false test bit, the next `car_q` equals `car_q`+1.
- R5: With `br_kind` 1 (call) and a true test bit, the next `car_q` equals `addr_fld`, and the saved return address becomes the old `car_q`+1.
- R6: With `br_kind` 2 (return), the next `car_q` equals the saved return address, whatever the test bit is.
- R7: With `br_kind` 3 (map), the next `car_q` has bits 5..2 equal to `opcode` and bits 6, 1 and 0 cleared.
- R8: Only a taken call changes the saved return address. A second taken call replaces the first one.
- R9: Increment wraps modulo 128, so 127 is followed by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Test-bit selector from the microinstruction |
| br_kind | input | 2 | Branch kind: 0 jump, 1 call, 2 return, 3 map |
| addr_fld | input | 7 | Branch target address from the microinstruction |
| st_indirect | input | 1 | Indirect-address bit of the data register |
| st_sign | input | 1 | Sign bit of the accumulator |
| st_zero | input | 1 | High when the accumulator is zero |
| opcode | input | 4 | Opcode bits taken from the data register |
| car_q | output | 7 | Current control-store address |

## Verification
A wrong next-address choice shows up on `car_q` one clock after the microinstruction that causes it. That makes a mis-decoded test bit or branch kind visible at once. A corrupted return register stays hidden until the next return, which can be many steps later. For that reason the stimulus issues returns often, both right after reset and right after taken and untaken calls. Checking `car_q` after those returns exposes a missing or spurious load of the return register.

// File: rtl/uaseq_pkg.sv
package uaseq_pkg;
  typedef enum logic [1:0] {
    BR_JUMP = 2'd0,
    BR_CALL = 2'd1,
    BR_RET  = 2'd2,
    BR_MAP  = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'd0,
    CND_IND    = 2'd1,
    CND_SIGN   = 2'd2,
    CND_ZERO   = 2'd3
  } cond_sel_e;

  // next-address mux source codes
  localparam logic [1:0] SRC_INC = 2'd0;
  localparam logic [1:0] SRC_FLD = 2'd1;
  localparam logic [1:0] SRC_RET = 2'd2;
  localparam logic [1:0] SRC_MAP = 2'd3;
endpackage

// File: rtl/uaseq_test_pick.sv
module uaseq_test_pick
  import uaseq_pkg::*;
(
  input  logic [1:0] cond_sel,
  input  logic       st_indirect,
  input  logic       st_sign,
  input  logic       st_zero,
  output logic       test_bit
);
  always_comb begin
    unique case (cond_sel_e'(cond_sel))
      CND_ALWAYS: test_bit = 1'b1;
      CND_IND:    test_bit = st_indirect;
      CND_SIGN:   test_bit = st_sign;
      default:    test_bit = st_zero;
    endcase
  end
endmodule

// File: rtl/uaseq_sel_logic.sv
module uaseq_sel_logic (
  input  logic [1:0] br_kind,
  input  logic       test_bit,
  output logic [1:0] src_sel,
  output logic       ret_load
);
  logic i1, i0;
  assign i1 = br_kind[1];
  assign i0 = br_kind[0];

  always_comb begin
    src_sel[1] = i1;
    src_sel[0] = (i1 & i0) | (~i1 & test_bit);
    ret_load   = ~i1 & i0 & test_bit;
  end
endmodule

// File: rtl/uaseq_addr_mux.sv
module uaseq_addr_mux
  import uaseq_pkg::*;
#(
  parameter int AW      = 7,
  parameter int OW      = 4,
  parameter int MAP_LSB = 2
) (
  input  logic [1:0]    src_sel,
  input  logic [AW-1:0] car_q,
  input  logic [AW-1:0] addr_fld,
  input  logic [AW-1:0] ret_q,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] car_inc,
  output logic [AW-1:0] car_nxt
);
  function automatic logic [AW-1:0] inc_of(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] map_of(input logic [OW-1:0] op);
    logic [AW-1:0] m;
    m = '0;
    m[MAP_LSB +: OW] = op;
    return m;
  endfunction

  logic [AW-1:0] map_addr;
  assign car_inc  = inc_of(car_q);
  assign map_addr = map_of(opcode);

  always_comb begin
    unique case (src_sel)
      SRC_INC: car_nxt = car_inc;
      SRC_FLD: car_nxt = addr_fld;
      SRC_RET: car_nxt = ret_q;
      default: car_nxt = map_addr;
    endcase
  end
endmodule

// File: rtl/uaddr_seq.sv
module uaddr_seq #(
  parameter int AW         = 7,
  parameter int OW         = 4,
  parameter int MAP_LSB    = 2,
  parameter int START_ADDR = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cond_sel,
  input  logic [1:0]    br_kind,
  input  logic [AW-1:0] addr_fld,
  input  logic          st_indirect,
  input  logic          st_sign,
  input  logic          st_zero,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] car_q
);
  localparam logic [AW-1:0] START_VAL = AW'(START_ADDR);

  // internal events, named for the checker
  logic          test_bit;
  logic [1:0]    src_sel;
  logic          sbr_load;
  logic [AW-1:0] sbr_q;
  logic [AW-1:0] car_inc;
  logic [AW-1:0] car_nxt;

  uaseq_test_pick u_test (
    .cond_sel    (cond_sel),
    .st_indirect (st_indirect),
    .st_sign     (st_sign),
    .st_zero     (st_zero),
    .test_bit    (test_bit)
  );

  uaseq_sel_logic u_sel (
    .br_kind  (br_kind),
    .test_bit (test_bit),
    .src_sel  (src_sel),
    .ret_load (sbr_load)
  );

  uaseq_addr_mux #(.AW(AW), .OW(OW), .MAP_LSB(MAP_LSB)) u_mux (
    .src_sel  (src_sel),
    .car_q    (car_q),
    .addr_fld (addr_fld),
    .ret_q    (sbr_q),
    .opcode   (opcode),
    .car_inc  (car_inc),
    .car_nxt  (car_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= START_VAL;
      sbr_q <= '0;
    end else begin
      car_q <= car_nxt;
      if (sbr_load) sbr_q <= car_inc;
    end
  end
endmodule

// File: rtl/uaseq_chk.sv
module uaseq_chk #(
  parameter int AW         = 7,
  parameter int OW         = 4,
  parameter int MAP_LSB    = 2,
  parameter int START_ADDR = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cond_sel,
  input logic [1:0]    br_kind,
  input logic [AW-1:0] addr_fld,
  input logic          st_indirect,
  input logic          st_sign,
  input logic          st_zero,
  input logic [OW-1:0] opcode,
  input logic [AW-1:0] car_q,
  input logic [AW-1:0] sbr_q,
  input logic          sbr_load
);
  logic t_chk;
  assign t_chk = (cond_sel == 2'd0) ? 1'b1 :
                 (cond_sel == 2'd1) ? st_indirect :
                 (cond_sel == 2'd2) ? st_sign : st_zero;

  // R1
  reset_start_chk: assert property (@(posedge clk)
    rst |=> (car_q == AW'(START_ADDR) && sbr_q == '0));

  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'd0 && t_chk) |=> car_q == $past(addr_fld));

  // R4
  no_take_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_kind[1] && !t_chk) |=> car_q == AW'($past(car_q) + 1'b1));

  // R5
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    sbr_load |=> (sbr_q == AW'($past(car_q) + 1'b1) && car_q == $past(addr_fld)));

  // R6
  ret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    br_kind == 2'd2 |=> car_q == $past(sbr_q));

  // R7
  map_form_chk: assert property (@(posedge clk) disable iff (rst)
    br_kind == 2'd3 |=> (car_q[MAP_LSB +: OW] == $past(opcode)
                         && car_q[MAP_LSB-1:0] == '0
                         && car_q[AW-1:MAP_LSB+OW] == '0));

  // R8
  sbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sbr_load |=> $stable(sbr_q));

  // R8
  load_only_call_chk: assert property (@(posedge clk) disable iff (rst)
    sbr_load |-> (br_kind == 2'd1 && t_chk));
endmodule

bind uaddr_seq uaseq_chk #(
  .AW(AW), .OW(OW), .MAP_LSB(MAP_LSB), .START_ADDR(START_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
  .addr_fld(addr_fld), .st_indirect(st_indirect), .st_sign(st_sign),
  .st_zero(st_zero), .opcode(opcode), .car_q(car_q), .sbr_q(sbr_q),
  .sbr_load(sbr_load)
);

// File: tb/uaddr_seq_tb_top.sv
module uaddr_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cond_sel = '0;
  logic [1:0] br_kind = '0;
  logic [6:0] addr_fld = '0;
  logic       st_indirect = 1'b0, st_sign = 1'b0, st_zero = 1'b0;
  logic [3:0] opcode = '0;
  logic [6:0] car_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  logic [6:0] m_car;
  logic [6:0] m_ret;

  always #10 clk = ~clk;  // 50 MHz

  uaddr_seq dut_i (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
    .addr_fld(addr_fld), .st_indirect(st_indirect), .st_sign(st_sign),
    .st_zero(st_zero), .opcode(opcode), .car_q(car_q)
  );

  function automatic bit pick_test(input logic [1:0] cs, input bit i, input bit s, input bit z);
    case (cs)
      2'd0: return 1'b1;
      2'd1: return i;
      2'd2: return s;
      default: return z;
    endcase
  endfunction

  function automatic string req_name(input logic [1:0] bk, input bit t);
    case (bk)
      2'd0: return t ? "R3" : "R4";
      2'd1: return t ? "R5" : "R4";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s car_q=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one microinstruction step: drive at negedge, compare at the following negedge
  task automatic step(input logic [1:0] cs, input logic [1:0] bk, input logic [6:0] ad,
                      input bit i, input bit s, input bit z, input logic [3:0] op,
                      input string tag);
    bit t;
    logic [6:0] nxt;
    cond_sel = cs; br_kind = bk; addr_fld = ad;
    st_indirect = i; st_sign = s; st_zero = z; opcode = op;
    t = pick_test(cs, i, s, z);
    case (bk)
      2'd0: nxt = t ? ad : m_car + 7'd1;
      2'd1: begin
        nxt = t ? ad : m_car + 7'd1;
        if (t) m_ret = m_car + 7'd1;
      end
      2'd2: nxt = m_ret;
      default: nxt = {1'b0, op, 2'b00};
    endcase
    m_car = nxt;
    @(negedge clk);
    check((tag == "") ? req_name(bk, t) : tag, car_q, m_car);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog car_q=%0d expected=finish", car_q);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    m_car = 7'd64; m_ret = 7'd0;
    check("R1", car_q, 7'd64);
    rst = 1'b0;
    // R1: return right after reset goes to cleared SBR
    step(2'd0, 2'd2, 7'd99, 0, 0, 0, 4'd0, "R1");
    // R2: each test source, both polarities (jump to 10 or increment)
    step(2'd1, 2'd0, 7'd10, 1, 0, 0, 4'd0, "R2");
    step(2'd1, 2'd0, 7'd20, 0, 1, 1, 4'd0, "R2");
    step(2'd2, 2'd0, 7'd30, 0, 1, 0, 4'd0, "R2");
    step(2'd2, 2'd0, 7'd40, 1, 0, 1, 4'd0, "R2");
    step(2'd3, 2'd0, 7'd50, 0, 0, 1, 4'd0, "R2");
    step(2'd3, 2'd0, 7'd60, 1, 1, 0, 4'd0, "R2");
    // R9: wrap from 127
    step(2'd0, 2'd0, 7'd127, 0, 0, 0, 4'd0, "R3");
    step(2'd1, 2'd0, 7'd5, 0, 0, 0, 4'd0, "R9");
    // R5/R8: call, untaken call, return
    step(2'd0, 2'd1, 7'd67, 0, 0, 0, 4'd0, "R5");
    step(2'd2, 2'd1, 7'd90, 0, 0, 0, 4'd0, "R4");
    step(2'd3, 2'd2, 7'd0, 0, 0, 1, 4'd0, "R8");
    // R8: nested call overwrites return address
    step(2'd0, 2'd1, 7'd100, 0, 0, 0, 4'd0, "R5");
    step(2'd1, 2'd1, 7'd20, 1, 0, 0, 4'd0, "R5");
    step(2'd0, 2'd2, 7'd0, 0, 0, 0, 4'd0, "R8");
    // R6: return with false test still returns
    step(2'd2, 2'd2, 7'd3, 0, 0, 0, 4'd0, "R6");
    // R7: map all-ones and mixed opcode
    step(2'd0, 2'd3, 7'd127, 1, 1, 1, 4'hF, "R7");
    step(2'd1, 2'd3, 7'd0, 0, 0, 0, 4'h5, "R7");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      step(2'($urandom), 2'($urandom), 7'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 4'($urandom), "");
    end
    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    m_car = 7'd64; m_ret = 7'd0;
    check("R1", car_q, 7'd64);
    rst = 1'b0;
    step(2'd0, 2'd2, 7'd9, 1, 1, 1, 4'd0, "R1");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule